// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that completes one instruction per clock: it fetches the word addressed by its program counter, decodes it, reads operands, computes through the ALU, optionally touches data memory and writes one register, all before the next rising edge. It understands nine operations. Two move words between registers and memory (load, store). Five combine two registers (add, subtract, AND, OR, signed set-less-than). One is a conditional branch when two registers are equal. One is an absolute jump.

Both memories sit outside the core. The fetch port presents the byte address of the current instruction and expects the word back combinationally. The data port presents address, write data and enables, and expects read data combinationally. The memory commits a store on the rising edge. A write-back port exposes the register write that the coming edge will perform, so the surrounding system can watch architectural progress.

Datapath selection is driven by a main decoder. It emits single-bit steering flags and a 2-bit operation class. A second decoder turns that class, together with the function field, into the ALU function. Instruction encodings that fall outside the subset retire as no-ops.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge the program counter becomes `RESET_PC` (0 by default) and, with `CLEAR_REGS` set, every register becomes zero. While `rst` is high, `wb_en_o` and `dmem_we_o` stay low.
- R2: Every instruction other than a taken branch or a jump advances the fetch address by 4. The fetch address is always word aligned.
- R3: Register-format words (opcode bits [31:26] = 0x00, bits [10:6] = 0) write `rs op rt` to register `rd`. Here rs = bits [25:21], rt = bits [20:16] and rd = bits [15:11]. The function field bits [5:0] selects the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed less-than giving 1 or 0.
- R4: A load (opcode 0x23) drives `dmem_addr_o` with `rs + sign-extended bits [15:0]` and writes the returned word to register rt.
- R5: A store (opcode 0x2B) raises `dmem_we_o` with the same address form and register rt as write data. It writes no register.
- R6: A branch (opcode 0x04) writes nothing. When rs equals rt the next fetch address is PC+4 plus the sign-extended offset times four, forward or backward. Otherwise it is PC+4.
- R7: A jump (opcode 0x02) loads the PC with PC bits [31:28], then bits [25:0] of the word, then two zero bits.
- R8: Register 0 reads as zero. A write aimed at it changes nothing and does not raise `wb_en_o`.
- R9: An unknown opcode, an unknown function code, or a register-format word with nonzero bits [10:6] writes no register, stores nothing and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr_o | output | 32 | Byte address of the instruction being executed |
| imem_data_i | input | 32 | Instruction word at `imem_addr_o` |
| dmem_addr_o | output | 32 | Data byte address (ALU result) |
| dmem_wdata_o | output | 32 | Store data |
| dmem_we_o | output | 1 | Store strobe, committed at the next rising edge |
| dmem_re_o | output | 1 | Load in progress |
| dmem_rdata_i | input | 32 | Word read at `dmem_addr_o` |
| wb_en_o | output | 1 | A register is written at the next rising edge |
| wb_reg_o | output | 5 | Index of the register being written |
| wb_data_o | output | 32 | Value being written |

## Verification
The bench builds the core with 32 registers, a reset address of 0 and register clearing enabled. This configuration gives full 5-bit register fields and a program that starts at word 0. The program loads every ordered pair from eight operands chosen at the signed and unsigned extremes, then runs all five ALU operations on each pair and stores every result. It then exercises a taken and an untaken branch, a backward branch, jumps, writes aimed at register 0, a negative load offset, store-then-reload, and three kinds of unrecognised encoding. A reset in the middle of the run followed by a read of previously written registers makes the register clearing observable at the write-back port.

// File: rtl/sc_pkg.sv
package sc_pkg;

   localparam int unsigned WORD_W    = 32;
   localparam int unsigned REG_IDX_W = 5;
   localparam int unsigned OPC_W     = 6;
   localparam int unsigned FUNC_W    = 6;
   localparam int unsigned SHAMT_W   = 5;
   localparam int unsigned IMM_W     = 16;
   localparam int unsigned JIDX_W    = 26;

   localparam logic [OPC_W-1:0] OPC_REG   = 6'h00;
   localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
   localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;
   localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;
   localparam logic [OPC_W-1:0] OPC_JUMP  = 6'h02;

   localparam logic [FUNC_W-1:0] FN_ADD = 6'h20;
   localparam logic [FUNC_W-1:0] FN_SUB = 6'h22;
   localparam logic [FUNC_W-1:0] FN_AND = 6'h24;
   localparam logic [FUNC_W-1:0] FN_OR  = 6'h25;
   localparam logic [FUNC_W-1:0] FN_SLT = 6'h2A;

   // operation class handed from the main decoder to the ALU decoder
   typedef enum logic [1:0] {
      CLS_ADD   = 2'b00,
      CLS_SUB   = 2'b01,
      CLS_FIELD = 2'b10
   } op_class_e;

   typedef enum logic [2:0] {
      ALU_ADD,
      ALU_SUB,
      ALU_AND,
      ALU_OR,
      ALU_SLT
   } alu_fn_e;

   // field layout of an instruction word
   typedef struct packed {
      logic [OPC_W-1:0]     opc;
      logic [REG_IDX_W-1:0] rs;
      logic [REG_IDX_W-1:0] rt;
      logic [REG_IDX_W-1:0] rd;
      logic [SHAMT_W-1:0]   shamt;
      logic [FUNC_W-1:0]    func;
   } insn_t;

   // steering produced by the main decoder
   typedef struct packed {
      logic      dst_from_rd;   // 1: write index from rd, 0: from rt
      logic      b_from_imm;    // 1: ALU operand b is the extended immediate
      logic      wb_from_mem;   // 1: write-back value comes from data memory
      logic      reg_wr;
      logic      mem_rd;
      logic      mem_wr;
      logic      is_branch;
      logic      is_jump;
      op_class_e cls;
   } steer_t;

endpackage

// File: rtl/sc_main_ctrl.sv
module sc_main_ctrl
   import sc_pkg::*;
(
   input  logic [OPC_W-1:0] opc,
   output steer_t           steer
);

   always_comb begin
      steer = '0;
      case (opc)
         OPC_REG: begin
            steer.dst_from_rd = 1'b1;
            steer.reg_wr      = 1'b1;
            steer.cls         = CLS_FIELD;
         end
         OPC_LOAD: begin
            steer.b_from_imm  = 1'b1;
            steer.wb_from_mem = 1'b1;
            steer.reg_wr      = 1'b1;
            steer.mem_rd      = 1'b1;
            steer.cls         = CLS_ADD;
         end
         OPC_STORE: begin
            steer.b_from_imm = 1'b1;
            steer.mem_wr     = 1'b1;
            steer.cls        = CLS_ADD;
         end
         OPC_BEQ: begin
            steer.is_branch = 1'b1;
            steer.cls       = CLS_SUB;
         end
         OPC_JUMP: begin
            steer.is_jump = 1'b1;
         end
         default: steer = '0;
      endcase
   end

endmodule

// File: rtl/sc_alu_ctrl.sv
module sc_alu_ctrl
   import sc_pkg::*;
(
   input  op_class_e          cls,
   input  logic [SHAMT_W-1:0] shamt,
   input  logic [FUNC_W-1:0]  func,
   output alu_fn_e            fn,
   output logic               fn_ok
);

   always_comb begin
      fn    = ALU_ADD;
      fn_ok = 1'b1;
      case (cls)
         CLS_ADD: fn = ALU_ADD;
         CLS_SUB: fn = ALU_SUB;
         CLS_FIELD: begin
            case (func)
               FN_ADD:  fn = ALU_ADD;
               FN_SUB:  fn = ALU_SUB;
               FN_AND:  fn = ALU_AND;
               FN_OR:   fn = ALU_OR;
               FN_SLT:  fn = ALU_SLT;
               default: fn_ok = 1'b0;
            endcase
            // the subset has no shift amount; a nonzero field is foreign
            if (shamt != '0) fn_ok = 1'b0;
         end
         default: fn_ok = 1'b0;
      endcase
   end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
   import sc_pkg::*;
#(
   parameter int unsigned W = 32
)(
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  alu_fn_e      fn,
   output logic [W-1:0] y,
   output logic         zero
);

   logic lt;

   assign lt = $signed(a) < $signed(b);

   always_comb begin
      case (fn)
         ALU_ADD: y = a + b;
         ALU_SUB: y = a - b;
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_SLT: y = {{(W-1){1'b0}}, lt};
         default: y = '0;
      endcase
   end

   assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
   import sc_pkg::*;
#(
   parameter int unsigned W            = 32,
   parameter int unsigned NREGS        = 32,
   parameter bit          CLEAR_ON_RST = 1'b1
)(
   input  logic                 clk,
   input  logic                 rst,
   input  logic [REG_IDX_W-1:0] ra1,
   input  logic [REG_IDX_W-1:0] ra2,
   input  logic [REG_IDX_W-1:0] wa,
   input  logic                 we,
   input  logic [W-1:0]         wd,
   output logic [W-1:0]         rd1,
   output logic [W-1:0]         rd2
);

   localparam int unsigned IDXW = $clog2(NREGS);

   logic [NREGS-1:0][W-1:0] bank;

   // entry 0 is a constant zero source
   assign bank[0] = '0;

   for (genvar g = 1; g < NREGS; g++) begin : g_reg
      logic [W-1:0] q;
      logic         hit;

      assign hit = we && (wa == REG_IDX_W'(g));

      if (CLEAR_ON_RST) begin : g_clear
         always_ff @(posedge clk) begin
            if (rst)      q <= '0;
            else if (hit) q <= wd;
         end
      end else begin : g_hold
         always_ff @(posedge clk) begin
            if (hit && !rst) q <= wd;
         end
      end

      assign bank[g] = q;
   end

   if (IDXW == REG_IDX_W) begin : g_full_rd
      assign rd1 = bank[ra1];
      assign rd2 = bank[ra2];
   end else begin : g_part_rd
      // indices past the implemented registers read as zero
      assign rd1 = (ra1 < REG_IDX_W'(NREGS)) ? bank[ra1[IDXW-1:0]] : '0;
      assign rd2 = (ra2 < REG_IDX_W'(NREGS)) ? bank[ra2[IDXW-1:0]] : '0;
   end

endmodule

// File: rtl/sc_next_pc.sv
module sc_next_pc
   import sc_pkg::*;
#(
   parameter int unsigned W  = 32,
   parameter int unsigned JW = 26
)(
   input  logic [W-1:0]  pc,
   input  logic [W-1:0]  offset,
   input  logic [JW-1:0] jidx,
   input  logic          take_branch,
   input  logic          take_jump,
   output logic [W-1:0]  next
);

   localparam int unsigned TOPW = W - JW - 2;

   logic [W-1:0] seq;
   logic [W-1:0] br;
   logic [W-1:0] jt;

   assign seq = pc + W'(4);
   assign br  = seq + (offset << 2);
   assign jt  = {pc[W-1 -: TOPW], jidx, 2'b00};

   always_comb begin
      if (take_jump)        next = jt;
      else if (take_branch) next = br;
      else                  next = seq;
   end

endmodule

// File: rtl/sc_core.sv
module sc_core
   import sc_pkg::*;
#(
   parameter int unsigned       NREGS      = 32,
   parameter logic [WORD_W-1:0] RESET_PC   = '0,
   parameter bit                CLEAR_REGS = 1'b1
)(
   input  logic                 clk,
   input  logic                 rst,
   output logic [WORD_W-1:0]    imem_addr_o,
   input  logic [WORD_W-1:0]    imem_data_i,
   output logic [WORD_W-1:0]    dmem_addr_o,
   output logic [WORD_W-1:0]    dmem_wdata_o,
   output logic                 dmem_we_o,
   output logic                 dmem_re_o,
   input  logic [WORD_W-1:0]    dmem_rdata_i,
   output logic                 wb_en_o,
   output logic [REG_IDX_W-1:0] wb_reg_o,
   output logic [WORD_W-1:0]    wb_data_o
);

   localparam int unsigned EXT_W = WORD_W - IMM_W;

   initial begin : p_param_check
      if (NREGS < 2 || NREGS > (1 << REG_IDX_W) || (NREGS & (NREGS - 1)) != 0)
         $fatal(1, "sc_core: NREGS must be a power of two from 2 to 32");
      if (RESET_PC[1:0] != 2'b00)
         $fatal(1, "sc_core: RESET_PC must be word aligned");
   end

   logic [WORD_W-1:0]    pc_q;
   logic [WORD_W-1:0]    pc_next;
   insn_t                insn;
   steer_t               steer;
   alu_fn_e              alu_fn;
   logic                 alu_ok;
   logic [WORD_W-1:0]    rs_val;
   logic [WORD_W-1:0]    rt_val;
   logic [WORD_W-1:0]    imm_ext;
   logic [WORD_W-1:0]    alu_b;
   logic [WORD_W-1:0]    alu_y;
   logic                 alu_zero;
   logic [REG_IDX_W-1:0] wr_idx;
   logic [WORD_W-1:0]    wr_val;
   logic                 commit;
   logic                 wr_go;

   assign insn   = insn_t'(imem_data_i);
   assign commit = !rst;

   sc_main_ctrl u_main_ctrl (
      .opc   (insn.opc),
      .steer (steer)
   );

   sc_alu_ctrl u_alu_ctrl (
      .cls   (steer.cls),
      .shamt (insn.shamt),
      .func  (insn.func),
      .fn    (alu_fn),
      .fn_ok (alu_ok)
   );

   assign imm_ext = {{EXT_W{imem_data_i[IMM_W-1]}}, imem_data_i[IMM_W-1:0]};
   assign wr_idx  = steer.dst_from_rd ? insn.rd : insn.rt;
   assign wr_go   = commit && steer.reg_wr && alu_ok && (wr_idx != '0);
   assign wr_val  = steer.wb_from_mem ? dmem_rdata_i : alu_y;

   sc_regfile #(
      .W            (WORD_W),
      .NREGS        (NREGS),
      .CLEAR_ON_RST (CLEAR_REGS)
   ) u_regfile (
      .clk (clk),
      .rst (rst),
      .ra1 (insn.rs),
      .ra2 (insn.rt),
      .wa  (wr_idx),
      .we  (wr_go),
      .wd  (wr_val),
      .rd1 (rs_val),
      .rd2 (rt_val)
   );

   assign alu_b = steer.b_from_imm ? imm_ext : rt_val;

   sc_alu #(
      .W (WORD_W)
   ) u_alu (
      .a    (rs_val),
      .b    (alu_b),
      .fn   (alu_fn),
      .y    (alu_y),
      .zero (alu_zero)
   );

   sc_next_pc #(
      .W  (WORD_W),
      .JW (JIDX_W)
   ) u_next_pc (
      .pc          (pc_q),
      .offset      (imm_ext),
      .jidx        (imem_data_i[JIDX_W-1:0]),
      .take_branch (steer.is_branch && alu_zero),
      .take_jump   (steer.is_jump),
      .next        (pc_next)
   );

   always_ff @(posedge clk) begin
      if (rst) pc_q <= RESET_PC;
      else     pc_q <= pc_next;
   end

   assign imem_addr_o  = pc_q;
   assign dmem_addr_o  = alu_y;
   assign dmem_wdata_o = rt_val;
   assign dmem_we_o    = commit && steer.mem_wr;
   assign dmem_re_o    = commit && steer.mem_rd;
   assign wb_en_o      = wr_go;
   assign wb_reg_o     = wr_idx;
   assign wb_data_o    = wr_val;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
   import sc_pkg::*;
#(
   parameter logic [WORD_W-1:0] RESET_PC = '0
)(
   input logic                 clk,
   input logic                 rst,
   input logic [WORD_W-1:0]    imem_addr_o,
   input logic [WORD_W-1:0]    imem_data_i,
   input logic                 dmem_we_o,
   input logic                 wb_en_o,
   input logic [REG_IDX_W-1:0] wb_reg_o
);

   logic [OPC_W-1:0] opc;
   logic             known;
   logic             rst_seen;

   assign opc   = imem_data_i[WORD_W-1 -: OPC_W];
   assign known = (opc == OPC_REG) || (opc == OPC_LOAD) || (opc == OPC_STORE) ||
                  (opc == OPC_BEQ) || (opc == OPC_JUMP);

   always_ff @(posedge clk) rst_seen <= rst;

   // R1: one edge with reset applied puts the PC at its reset value
   always @(negedge clk) begin
      if (rst_seen === 1'b1)
         assert_reset_pc_R1: assert (imem_addr_o == RESET_PC);
   end

   // R1: no architectural write escapes while reset is held
   always @(negedge clk) begin
      if (rst === 1'b1)
         assert_quiet_in_reset_R1: assert (!dmem_we_o && !wb_en_o);
   end

   assert_aligned_R2: assert property (@(posedge clk) disable iff (rst)
      imem_addr_o[1:0] == 2'b00);

   assert_sequential_R2: assert property (@(posedge clk) disable iff (rst)
      (opc != OPC_BEQ && opc != OPC_JUMP) |=> imem_addr_o == $past(imem_addr_o) + 32'd4);

   assert_store_no_wb_R5: assert property (@(posedge clk) disable iff (rst)
      dmem_we_o |-> !wb_en_o);

   assert_jump_target_R7: assert property (@(posedge clk) disable iff (rst)
      (opc == OPC_JUMP) |=> imem_addr_o == {$past(imem_addr_o[31:28]), $past(imem_data_i[25:0]), 2'b00});

   assert_zero_reg_R8: assert property (@(posedge clk) disable iff (rst)
      wb_en_o |-> wb_reg_o != '0);

   assert_foreign_inert_R9: assert property (@(posedge clk) disable iff (rst)
      !known |-> (!wb_en_o && !dmem_we_o));

endmodule

bind sc_core sc_core_chk #(
   .RESET_PC (RESET_PC)
) u_sc_core_chk (
   .clk         (clk),
   .rst         (rst),
   .imem_addr_o (imem_addr_o),
   .imem_data_i (imem_data_i),
   .dmem_we_o   (dmem_we_o),
   .wb_en_o     (wb_en_o),
   .wb_reg_o    (wb_reg_o)
);

// File: tb/test_sc_core.sv
module test_sc_core;

   localparam logic [5:0] T_REG = 6'h00, T_LW = 6'h23, T_SW = 6'h2B, T_BEQ = 6'h04, T_J = 6'h02;
   localparam logic [5:0] T_ADD = 6'h20, T_SUB = 6'h22, T_AND = 6'h24, T_OR = 6'h25, T_SLT = 6'h2A;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata, wb_data;
   logic        dmem_we, dmem_re, wb_en;
   logic [4:0]  wb_reg;

   int n_chk = 0;
   int n_err = 0;

   logic [31:0] rom [0:1023];
   logic [31:0] ram [0:511];
   logic [31:0] rreg [0:31];
   logic [31:0] rpc;
   string       pc_tag;
   int          halt_idx;

   sc_core #(
      .NREGS      (32),
      .RESET_PC   (32'h0),
      .CLEAR_REGS (1'b1)
   ) i_sc_core (
      .clk          (clk),
      .rst          (rst),
      .imem_addr_o  (imem_addr),
      .imem_data_i  (imem_data),
      .dmem_addr_o  (dmem_addr),
      .dmem_wdata_o (dmem_wdata),
      .dmem_we_o    (dmem_we),
      .dmem_re_o    (dmem_re),
      .dmem_rdata_i (dmem_rdata),
      .wb_en_o      (wb_en),
      .wb_reg_o     (wb_reg),
      .wb_data_o    (wb_data)
   );

   always #2 clk = ~clk;

   assign imem_data  = rom[imem_addr[11:2]];
   assign dmem_rdata = ram[dmem_addr[10:2]];

   function automatic logic [31:0] operand(int k);
      case (k)
         0: return 32'h0000_0000;
         1: return 32'h0000_0001;
         2: return 32'hFFFF_FFFF;
         3: return 32'h7FFF_FFFF;
         4: return 32'h8000_0000;
         5: return 32'h1234_5678;
         6: return 32'hFFFF_0000;
         default: return 32'h0000_0005;
      endcase
   endfunction

   function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
      return {T_REG, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
   endfunction

   function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int off);
      return {op, 5'(rs), 5'(rt), 16'(off)};
   endfunction

   function automatic logic [31:0] enc_j(int idx);
      return {T_J, 26'(idx)};
   endfunction

   // data memory: preload, then commit stores at the rising edge
   initial begin : p_ram
      for (int k = 0; k < 512; k++) ram[k] = 32'h0;
      for (int k = 0; k < 8; k++) ram[k] = operand(k);
      ram[8]  = 32'h0000_0040;
      ram[15] = 32'hC0DE_BEEF;
      forever begin
         @(posedge clk);
         if (dmem_we === 1'b1) ram[dmem_addr[10:2]] <= dmem_wdata;
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic ref_clear();
      rpc    = 32'h0;
      pc_tag = "R1 first fetch";
      for (int k = 0; k < 32; k++) rreg[k] = 32'h0;
   endtask

   // compare one retiring instruction against the bench model, then advance
   task automatic step();
      logic [31:0] ins, a, b, sx, val, nxt, addr;
      logic        wen, st;
      int          wr;
      string       tag, ntag;
      ins  = rom[rpc[11:2]];
      chk({pc_tag, " fetch address"}, imem_addr, rpc);
      a    = rreg[ins[25:21]];
      b    = rreg[ins[20:16]];
      sx   = {{16{ins[15]}}, ins[15:0]};
      wen  = 1'b0; st = 1'b0; wr = 0; val = 32'h0; addr = 32'h0;
      nxt  = rpc + 32'd4;
      ntag = "R2";
      case (ins[31:26])
         T_REG: begin
            wr = int'(ins[15:11]); wen = 1'b1; tag = "R3";
            case (ins[5:0])
               T_ADD: val = a + b;
               T_SUB: val = a - b;
               T_AND: val = a & b;
               T_OR:  val = a | b;
               T_SLT: val = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
               default: begin wen = 1'b0; tag = "R9"; end
            endcase
            if (ins[10:6] != 5'd0) begin wen = 1'b0; tag = "R9"; end
         end
         T_LW: begin
            wr = int'(ins[20:16]); addr = a + sx; val = ram[addr[10:2]]; wen = 1'b1; tag = "R4";
            chk("R4 load address", dmem_addr, addr);
         end
         T_SW: begin st = 1'b1; addr = a + sx; tag = "R5"; end
         T_BEQ: begin
            tag = "R6"; ntag = "R6";
            if (a == b) nxt = rpc + 32'd4 + (sx << 2);
         end
         T_J: begin tag = "R7"; ntag = "R7"; nxt = {rpc[31:28], ins[25:0], 2'b00}; end
         default: tag = "R9";
      endcase
      if (wen && wr == 0) begin wen = 1'b0; tag = "R8"; end
      chk({tag, " write enable"}, 32'(wb_en), 32'(wen));
      if (wen) begin
         chk({tag, " write index"}, 32'(wb_reg), 32'(wr));
         chk({tag, " write value"}, wb_data, val);
      end
      chk({tag, " store enable"}, 32'(dmem_we), 32'(st));
      if (st) begin
         chk({tag, " store address"}, dmem_addr, addr);
         chk({tag, " store data"}, dmem_wdata, b);
      end
      if (wen) rreg[wr] = val;
      rpc    = nxt;
      pc_tag = ntag;
      @(negedge clk);
      #1;
   endtask

   initial begin : p_watchdog
      repeat (50000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected program end");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin : p_main
      int p, k, j1, j2, back, fwd, after, guard;
      for (int m = 0; m < 1024; m++) rom[m] = 32'hFC00_0000;
      p = 0;
      // word 0 reads r15 and r11, which only hold data before a reset (R1)
      rom[p++] = enc_r(15, 11, 21, T_OR);
      // R3 sweep: every ordered operand pair through all five functions
      k = 0;
      for (int i = 0; i < 8; i++) begin
         for (int j = 0; j < 8; j++) begin
            rom[p++] = enc_i(T_LW, 0, 1, 4 * i);
            rom[p++] = enc_i(T_LW, 0, 2, 4 * j);
            rom[p++] = enc_r(1, 2, 3, T_ADD);
            rom[p++] = enc_r(1, 2, 4, T_SUB);
            rom[p++] = enc_r(1, 2, 5, T_AND);
            rom[p++] = enc_r(1, 2, 6, T_OR);
            rom[p++] = enc_r(1, 2, 7, T_SLT);
            for (int s = 0; s < 5; s++) begin
               rom[p++] = enc_i(T_SW, 0, 3 + s, 256 + 4 * k);
               k++;
            end
         end
      end
      // R6: taken forward branch skips two writers
      rom[p++] = enc_i(T_LW, 0, 8, 8);
      rom[p++] = enc_i(T_LW, 0, 9, 8);
      rom[p++] = enc_i(T_BEQ, 8, 9, 2);
      rom[p++] = enc_r(8, 8, 10, T_ADD);
      rom[p++] = enc_r(9, 9, 10, T_ADD);
      rom[p++] = enc_r(8, 9, 11, T_ADD);
      // R6: not taken
      rom[p++] = enc_i(T_BEQ, 8, 1, 1);
      rom[p++] = enc_r(8, 1, 12, T_ADD);
      // R7 jumps around a backward R6 branch
      j1 = p; p++;
      back = p; rom[p++] = enc_r(8, 1, 13, T_SUB);
      j2 = p; p++;
      fwd = p; rom[p++] = enc_i(T_BEQ, 0, 0, back - (fwd + 1));
      after = p;
      rom[j1] = enc_j(fwd);
      rom[j2] = enc_j(after);
      // R8: writes aimed at register 0
      rom[p++] = enc_r(8, 9, 0, T_ADD);
      rom[p++] = enc_i(T_LW, 0, 0, 20);
      rom[p++] = enc_r(0, 0, 14, T_OR);
      rom[p++] = enc_r(8, 0, 19, T_ADD);
      // R9: foreign opcode, foreign function, nonzero shift field
      rom[p++] = 32'hFC00_0000;
      rom[p++] = enc_r(8, 9, 17, 6'h27);
      rom[p++] = enc_r(8, 9, 17, T_ADD) | 32'h0000_0040;
      // R4 negative offset, R5 store then reload
      rom[p++] = enc_i(T_LW, 0, 16, 32);
      rom[p++] = enc_i(T_LW, 16, 15, -4);
      rom[p++] = enc_i(T_SW, 16, 15, -8);
      rom[p++] = enc_i(T_LW, 0, 18, 56);
      halt_idx = p;
      rom[p++] = enc_i(T_BEQ, 0, 0, -1);

      // R1: held reset
      rst = 1'b1;
      repeat (3) begin
         @(negedge clk); #1;
         chk("R1 reset fetch address", imem_addr, 32'h0);
         chk("R1 reset write enable", 32'(wb_en), 32'h0);
         chk("R1 reset store enable", 32'(dmem_we), 32'h0);
      end
      rst = 1'b0;
      #1;
      ref_clear();
      guard = 0;
      while (rpc != 32'(halt_idx * 4) && guard < 5000) begin
         step();
         guard++;
      end
      chk("R2 program reached end", rpc, 32'(halt_idx * 4));
      repeat (3) step();

      // R1: reset in the middle of a run, then reread formerly written registers
      rst = 1'b1;
      repeat (2) begin
         @(negedge clk); #1;
         chk("R1 mid-run reset fetch address", imem_addr, 32'h0);
         chk("R1 mid-run reset write enable", 32'(wb_en), 32'h0);
         chk("R1 mid-run reset store enable", 32'(dmem_we), 32'h0);
      end
      rst = 1'b0;
      #1;
      ref_clear();
      chk("R1 cleared registers read back", wb_data, 32'h0);
      repeat (6) step();

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule